// File: doc/BRIEF.md
# Wide Register Access Collector

This bridge sits between a 32-bit host port and a block of wide storage: 128-bit control/status registers and 64-bit SRAM words. The host moves one dword per access. The bridge makes each wide access behave as a single atomic event. On a read, it captures the whole wide word in a latch and serves the other dwords of that word from the latch. On a write, it gathers dwords in a collector and performs one wide write only when every dword of the word is present.

Two descriptor-pointer registers follow their own rules so that a host can update them without taking a lock. A write to their top dword always commits the register. Any low dword the collector does not hold for that register is filled with zero. A write to one of their lower dwords is dropped when the collector is busy with some other register. Plain 32-bit registers go straight through to a narrow port and leave the collector and the latch alone.

Top module: `wide_access_bridge`

## Requirements
- R1: After reset, no write strobe is active, `host_rvalid` is 0, and the collector and the read latch are both empty.
- R2: Address decode works on `host_addr`, a dword address. When bit 11 is 1, the access goes to SRAM: word index is bits 10:1 and dword is bit 0. When bit 11 is 0, the access goes to CSR space: register index is bits 10:2 and dword is bits 1:0. Index 0x083 and index 0x0A1 are the descriptor registers. Indices 0x100 and above are plain 32-bit registers, and the narrow address is bits 10:0. Dword n occupies bits 32n+31:32n of the wide word.
- R3: A wide read samples the storage when it targets dword 0, when the latch is empty, or when the latch holds a different word. Sampling gives one `csr_rd_en` or `sram_rd_en` pulse in the cycle of `host_rd` and captures the whole word. In every case, `host_rvalid` and `host_rdata` appear one cycle after `host_rd`.
- R4: A read of dword 1 or higher of the word already latched returns the latched value. It gives no read strobe, even if the storage has changed since the latch was filled.
- R5: A wide CSR or SRAM write commits one cycle after the dword that completes the word: 4 dwords for a CSR, 2 for SRAM, in any order. No write strobe is given before that.
- R6: A wide CSR or SRAM write to a different word than the one whose partial data the collector holds restarts the collector with the new word. The old partial data is lost.
- R7: A descriptor write to dword 3 always commits, one cycle later. Dwords 0 to 2 are taken from the collector where it holds them for that register, and are zero otherwise. The collector is emptied if it held that register or was empty. It is kept if it held another word.
- R8: A descriptor write to dword 0, 1 or 2 is discarded when the collector holds data for another word. The collector's contents stay unchanged.
- R9: The descriptor registers are write-only. A read of them returns 0 with `host_rvalid`, gives no read strobe and leaves the latch unchanged.
- R10: A plain-register write appears on `nar_wr_*` one cycle later. A plain-register read pulses `nar_rd_en` in the same cycle and returns `nar_rd_data` one cycle later. Neither access touches the collector or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host dword write |
| host_rd | input | 1 | Host dword read |
| host_addr | input | 12 | Host dword address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, one cycle after `host_rd` |
| host_rvalid | output | 1 | `host_rdata` valid |
| csr_rd_en | output | 1 | Wide CSR sample strobe |
| csr_rd_idx | output | 9 | CSR register index to sample |
| csr_rd_data | input | 128 | CSR value, same cycle |
| sram_rd_en | output | 1 | SRAM sample strobe |
| sram_rd_idx | output | 10 | SRAM word index to sample |
| sram_rd_data | input | 64 | SRAM word, same cycle |
| nar_rd_en | output | 1 | Plain register read strobe |
| nar_rd_addr | output | 11 | Plain register address |
| nar_rd_data | input | 32 | Plain register value, same cycle |
| csr_wr_en | output | 1 | Wide CSR write strobe |
| csr_wr_idx | output | 9 | CSR register index written |
| csr_wr_data | output | 128 | CSR write value |
| sram_wr_en | output | 1 | SRAM write strobe |
| sram_wr_idx | output | 10 | SRAM word index written |
| sram_wr_data | output | 64 | SRAM write value |
| nar_wr_en | output | 1 | Plain register write strobe |
| nar_wr_addr | output | 11 | Plain register address written |
| nar_wr_data | output | 32 | Plain register write value |

## Verification
The assertions assume that `host_rd` and `host_wr` are never high in the same cycle. They also assume that an SRAM access uses only dwords 0 and 1, which holds by construction because SRAM dword selection uses a single address bit. The checker states the first assumption as a property of its own. The bench issues one access at a time, each followed by an idle cycle, and changes storage contents only between accesses. Its random phase draws from a small pool of word addresses so that collector conflicts, restarts and stale latch hits occur often.

// File: rtl/wab_pkg.sv
package wab_pkg;

    localparam int DWORD_W = 32;
    localparam int CSR_DW  = 4;
    localparam int SRAM_DW = 2;
    localparam int WIDE_W  = DWORD_W * CSR_DW;
    localparam int SRAM_W  = DWORD_W * SRAM_DW;
    localparam int LAST_DW = CSR_DW - 1;

    typedef logic [DWORD_W-1:0] dword_t;
    typedef logic [WIDE_W-1:0]  wide_t;
    typedef logic [CSR_DW-1:0]  dmask_t;

    typedef enum logic [1:0] {
        ACC_WIDE   = 2'd0,
        ACC_SRAM   = 2'd1,
        ACC_DESC   = 2'd2,
        ACC_NARROW = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [1:0] dw;
    } acc_dec_t;

    // Mask of the dwords that make a complete word of the given space.
    function automatic dmask_t full_mask(input logic is_sram);
        dmask_t m;
        for (int i = 0; i < CSR_DW; i++)
            m[i] = is_sram ? (i < SRAM_DW) : 1'b1;
        return m;
    endfunction

    function automatic dword_t pick_dw(input wide_t w, input logic [1:0] sel);
        return w[sel*DWORD_W +: DWORD_W];
    endfunction

endpackage

// File: rtl/wab_decode.sv
module wab_decode
    import wab_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int RX_IDX      = 'h083,
    parameter int TX_IDX      = 'h0A1,
    parameter int NARROW_BASE = 'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec,
    output logic [ADDR_W-3:0] idx
);
    localparam int CIDX_W = ADDR_W - 3;

    logic [CIDX_W-1:0] csr_idx;

    always_comb begin
        csr_idx = addr[ADDR_W-2:2];
        if (addr[ADDR_W-1]) begin
            dec.kind = ACC_SRAM;
            dec.dw   = {1'b0, addr[0]};
            idx      = addr[ADDR_W-2:1];
        end else begin
            dec.dw = addr[1:0];
            idx    = {1'b0, csr_idx};
            if (csr_idx >= CIDX_W'(NARROW_BASE))
                dec.kind = ACC_NARROW;
            else if (csr_idx == CIDX_W'(RX_IDX) || csr_idx == CIDX_W'(TX_IDX))
                dec.kind = ACC_DESC;
            else
                dec.kind = ACC_WIDE;
        end
    end

endmodule

// File: rtl/wab_read_latch.sv
module wab_read_latch
    import wab_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic [TAG_W-1:0] tag,
    input  logic [1:0]       dw,
    input  wide_t            fresh,
    output logic             need_sample,
    output dword_t           rd_dword
);
    logic             lat_valid;
    logic [TAG_W-1:0] lat_tag;
    wide_t            lat_data;

    assign need_sample = rd && (!lat_valid || dw == 2'd0 || lat_tag != tag);
    assign rd_dword    = need_sample ? pick_dw(fresh, dw) : pick_dw(lat_data, dw);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_valid <= 1'b0;
            lat_tag   <= '0;
            lat_data  <= '0;
        end else if (need_sample) begin
            lat_valid <= 1'b1;
            lat_tag   <= tag;
            lat_data  <= fresh;
        end
    end

endmodule

// File: rtl/wab_collector.sv
module wab_collector
    import wab_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  acc_kind_e        kind,
    input  logic [TAG_W-1:0] tag,
    input  logic [1:0]       dw,
    input  dword_t           wdata,
    output logic             commit_en,
    output logic [TAG_W-1:0] commit_tag,
    output wide_t            commit_data,
    output dmask_t           col_mask,
    output logic [TAG_W-1:0] col_tag
);
    wide_t  col_data;
    dmask_t n_mask, base_m;
    wide_t  n_data, base_d, c_data;
    logic [TAG_W-1:0] n_tag;
    logic   hit, do_commit;

    always_comb begin
        n_mask    = col_mask;
        n_tag     = col_tag;
        n_data    = col_data;
        do_commit = 1'b0;
        c_data    = '0;
        hit       = (col_mask == '0) || (col_tag == tag);
        base_m    = hit ? col_mask : '0;
        base_d    = hit ? col_data : '0;
        if (wr) begin
            unique case (kind)
                ACC_WIDE, ACC_SRAM: begin
                    base_m[dw]                 = 1'b1;
                    base_d[dw*DWORD_W +: DWORD_W] = wdata;
                    if (base_m == full_mask(kind == ACC_SRAM)) begin
                        do_commit = 1'b1;
                        c_data    = base_d;
                        n_mask    = '0;
                        n_data    = '0;
                    end else begin
                        n_mask = base_m;
                        n_data = base_d;
                        n_tag  = tag;
                    end
                end
                ACC_DESC: begin
                    if (dw == 2'(LAST_DW)) begin
                        do_commit = 1'b1;
                        for (int i = 0; i < LAST_DW; i++)
                            c_data[i*DWORD_W +: DWORD_W] =
                                (col_mask[i] && col_tag == tag) ? col_data[i*DWORD_W +: DWORD_W] : '0;
                        c_data[LAST_DW*DWORD_W +: DWORD_W] = wdata;
                        if (hit) begin
                            n_mask = '0;
                            n_data = '0;
                        end
                    end else if (hit) begin
                        n_mask[dw]                    = 1'b1;
                        n_data[dw*DWORD_W +: DWORD_W] = wdata;
                        n_tag                         = tag;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_mask    <= '0;
            col_tag     <= '0;
            col_data    <= '0;
            commit_en   <= 1'b0;
            commit_tag  <= '0;
            commit_data <= '0;
        end else begin
            col_mask  <= n_mask;
            col_tag   <= n_tag;
            col_data  <= n_data;
            commit_en <= do_commit;
            if (do_commit) begin
                commit_tag  <= tag;
                commit_data <= c_data;
            end
        end
    end

endmodule

// File: rtl/wide_access_bridge.sv
module wide_access_bridge
    import wab_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int RX_IDX      = 'h083,
    parameter int TX_IDX      = 'h0A1,
    parameter int NARROW_BASE = 'h100,
    localparam int CIDX_W     = ADDR_W - 3,
    localparam int SIDX_W     = ADDR_W - 2,
    localparam int NADDR_W    = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_rvalid,
    output logic               csr_rd_en,
    output logic [CIDX_W-1:0]  csr_rd_idx,
    input  logic [127:0]       csr_rd_data,
    output logic               sram_rd_en,
    output logic [SIDX_W-1:0]  sram_rd_idx,
    input  logic [63:0]        sram_rd_data,
    output logic               nar_rd_en,
    output logic [NADDR_W-1:0] nar_rd_addr,
    input  logic [31:0]        nar_rd_data,
    output logic               csr_wr_en,
    output logic [CIDX_W-1:0]  csr_wr_idx,
    output logic [127:0]       csr_wr_data,
    output logic               sram_wr_en,
    output logic [SIDX_W-1:0]  sram_wr_idx,
    output logic [63:0]        sram_wr_data,
    output logic               nar_wr_en,
    output logic [NADDR_W-1:0] nar_wr_addr,
    output logic [31:0]        nar_wr_data
);
    localparam int TAG_W = SIDX_W + 1;

    acc_dec_t          dec;
    logic [SIDX_W-1:0] dec_idx;
    logic [TAG_W-1:0]  dec_tag;
    logic              wide_rd, need_sample, commit_en;
    dword_t            lat_dword;
    wide_t             fresh, commit_data;
    logic [TAG_W-1:0]  commit_tag, col_tag;
    dmask_t            col_mask;

    wab_decode #(
        .ADDR_W(ADDR_W), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX), .NARROW_BASE(NARROW_BASE)
    ) i_decode (
        .addr(host_addr), .dec(dec), .idx(dec_idx)
    );

    assign dec_tag = {dec.kind == ACC_SRAM, dec_idx};
    assign wide_rd = host_rd && (dec.kind == ACC_WIDE || dec.kind == ACC_SRAM);
    assign fresh   = (dec.kind == ACC_SRAM) ? {{(WIDE_W-SRAM_W){1'b0}}, sram_rd_data} : csr_rd_data;

    wab_read_latch #(.TAG_W(TAG_W)) i_latch (
        .clk(clk), .rst(rst), .rd(wide_rd), .tag(dec_tag), .dw(dec.dw),
        .fresh(fresh), .need_sample(need_sample), .rd_dword(lat_dword)
    );

    wab_collector #(.TAG_W(TAG_W)) i_collector (
        .clk(clk), .rst(rst), .wr(host_wr), .kind(dec.kind), .tag(dec_tag),
        .dw(dec.dw), .wdata(host_wdata), .commit_en(commit_en),
        .commit_tag(commit_tag), .commit_data(commit_data),
        .col_mask(col_mask), .col_tag(col_tag)
    );

    // Storage-side read requests
    assign csr_rd_en   = need_sample && dec.kind == ACC_WIDE;
    assign csr_rd_idx  = dec_idx[CIDX_W-1:0];
    assign sram_rd_en  = need_sample && dec.kind == ACC_SRAM;
    assign sram_rd_idx = dec_idx;
    assign nar_rd_en   = host_rd && dec.kind == ACC_NARROW;
    assign nar_rd_addr = host_addr[NADDR_W-1:0];

    // Storage-side wide writes
    assign csr_wr_en    = commit_en && !commit_tag[TAG_W-1];
    assign csr_wr_idx   = commit_tag[CIDX_W-1:0];
    assign csr_wr_data  = commit_data;
    assign sram_wr_en   = commit_en && commit_tag[TAG_W-1];
    assign sram_wr_idx  = commit_tag[SIDX_W-1:0];
    assign sram_wr_data = commit_data[SRAM_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
            nar_wr_en   <= 1'b0;
            nar_wr_addr <= '0;
            nar_wr_data <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                unique case (dec.kind)
                    ACC_WIDE, ACC_SRAM: host_rdata <= lat_dword;
                    ACC_NARROW:         host_rdata <= nar_rd_data;
                    default:            host_rdata <= '0;
                endcase
            end
            nar_wr_en <= host_wr && dec.kind == ACC_NARROW;
            if (host_wr && dec.kind == ACC_NARROW) begin
                nar_wr_addr <= host_addr[NADDR_W-1:0];
                nar_wr_data <= host_wdata;
            end
        end
    end

endmodule

// File: rtl/wab_checker.sv
module wab_checker
    import wab_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic             host_rvalid,
    input logic             csr_rd_en,
    input logic             sram_rd_en,
    input logic             csr_wr_en,
    input logic             sram_wr_en,
    input acc_kind_e        kind,
    input logic [1:0]       dw,
    input logic [TAG_W-1:0] tag,
    input logic [TAG_W-1:0] col_tag,
    input dmask_t           col_mask
);
    // Input assumption: one host access per cycle
    host_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_wr));

    // R5
    commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en || sram_wr_en) |-> $past(host_wr));

    // R3
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    // R4
    strobe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_en || sram_rd_en) |-> host_rd);

    // R9
    desc_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && kind == ACC_DESC) |-> !(csr_rd_en || sram_rd_en));

    // R10
    narrow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && kind == ACC_NARROW) |=>
            ($stable(col_mask) && $stable(col_tag) && !csr_wr_en && !sram_wr_en));

    // R8
    desc_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && kind == ACC_DESC && dw != 2'd3 && col_mask != '0 && col_tag != tag) |=>
            ($stable(col_mask) && $stable(col_tag) && !csr_wr_en));

endmodule

bind wide_access_bridge wab_checker #(.TAG_W(TAG_W)) i_wab_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_rvalid(host_rvalid), .csr_rd_en(csr_rd_en), .sram_rd_en(sram_rd_en),
    .csr_wr_en(csr_wr_en), .sram_wr_en(sram_wr_en), .kind(dec.kind),
    .dw(dec.dw), .tag(dec_tag), .col_tag(col_tag), .col_mask(col_mask)
);

// File: tb/test_wide_access_bridge.sv
`timescale 1ns/1ps
module test_wide_access_bridge;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         host_wr = 1'b0, host_rd = 1'b0;
    logic [11:0]  host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_rvalid;
    logic         csr_rd_en, sram_rd_en, nar_rd_en;
    logic [8:0]   csr_rd_idx;
    logic [9:0]   sram_rd_idx;
    logic [10:0]  nar_rd_addr;
    logic [127:0] csr_rd_data;
    logic [63:0]  sram_rd_data;
    logic [31:0]  nar_rd_data;
    logic         csr_wr_en, sram_wr_en, nar_wr_en;
    logic [8:0]   csr_wr_idx;
    logic [9:0]   sram_wr_idx;
    logic [10:0]  nar_wr_addr;
    logic [127:0] csr_wr_data;
    logic [63:0]  sram_wr_data;
    logic [31:0]  nar_wr_data;

    wide_access_bridge i_wide_access_bridge (.*);

    // Storage model owned by the bench
    bit [127:0] csr_mem  [512];
    bit [63:0]  sram_mem [1024];
    bit [31:0]  nar_mem  [2048];
    logic         poke_en = 1'b0, poke_sram = 1'b0;
    int           poke_idx = 0;
    logic [127:0] poke_val = '0;

    assign csr_rd_data  = csr_mem[csr_rd_idx];
    assign sram_rd_data = sram_mem[sram_rd_idx];
    assign nar_rd_data  = nar_mem[nar_rd_addr];

    always @(posedge clk) begin
        if (csr_wr_en)  csr_mem[csr_wr_idx]   <= csr_wr_data;
        if (sram_wr_en) sram_mem[sram_wr_idx] <= sram_wr_data;
        if (nar_wr_en)  nar_mem[nar_wr_addr]  <= nar_wr_data;
        if (poke_en) begin
            if (poke_sram) sram_mem[poke_idx] <= poke_val[63:0];
            else           csr_mem[poke_idx]  <= poke_val;
        end
    end

    int nchk = 0, nfail = 0;
    bit done = 0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model state
    logic [3:0]   m_mask = '0;
    int           m_tag = 0;
    logic [127:0] m_data = '0;
    bit           m_lv = 0;
    int           m_lt = 0;
    logic [127:0] m_ld = '0;

    // R2 address map: 0 wide, 1 sram, 2 descriptor, 3 narrow
    task automatic decode(input logic [11:0] a, output int kind, output int idx, output int dw);
        if (a[11]) begin
            kind = 1; idx = int'(a[10:1]); dw = int'(a[0]);
        end else begin
            idx = int'(a[10:2]); dw = int'(a[1:0]);
            kind = (idx >= 'h100) ? 3 : ((idx == 'h083 || idx == 'h0A1) ? 2 : 0);
        end
    endtask

    function automatic logic [11:0] csr_a(input int idx, input int dw);
        return {1'b0, 9'(idx), 2'(dw)};
    endfunction
    function automatic logic [11:0] sram_a(input int idx, input int dw);
        return {1'b1, 10'(idx), 1'(dw)};
    endfunction

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic poke(input bit s, input int idx, input logic [127:0] v);
        poke_en = 1; poke_sram = s; poke_idx = idx; poke_val = v;
        @(posedge clk); @(negedge clk);
        poke_en = 0;
    endtask

    task automatic op_write(input logic [11:0] a, input logic [31:0] d, input string req);
        int kind, idx, dw, t;
        bit hit, exp_c;
        logic [3:0] bm, full;
        logic [127:0] bd, exp_d;
        decode(a, kind, idx, dw);
        t = (kind == 1) ? 4096 + idx : idx;
        hit = (m_mask == 0) || (m_tag == t);
        exp_c = 0; exp_d = '0;
        full = (kind == 1) ? 4'b0011 : 4'b1111;
        if (kind <= 1) begin
            bm = hit ? m_mask : 4'b0; bd = hit ? m_data : '0;
            bm[dw] = 1'b1; bd[dw*32 +: 32] = d;
            if (bm == full) begin
                exp_c = 1; exp_d = bd; m_mask = 0; m_data = '0;
            end else begin
                m_mask = bm; m_data = bd; m_tag = t;
            end
        end else if (kind == 2) begin
            if (dw == 3) begin
                exp_c = 1;
                for (int i = 0; i < 3; i++)
                    exp_d[i*32 +: 32] = (m_mask[i] && m_tag == t) ? m_data[i*32 +: 32] : 32'h0;
                exp_d[127:96] = d;
                if (hit) begin m_mask = 0; m_data = '0; end
            end else if (hit) begin
                m_mask[dw] = 1'b1; m_data[dw*32 +: 32] = d; m_tag = t;
            end
        end
        host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk); @(negedge clk);
        host_wr = 0;
        check({req, " csr strobe"}, 128'(csr_wr_en), 128'(exp_c && kind != 1));
        check({req, " sram strobe"}, 128'(sram_wr_en), 128'(exp_c && kind == 1));
        if (exp_c && kind != 1) begin
            check({req, " csr idx"}, 128'(csr_wr_idx), 128'(idx));
            check({req, " csr data"}, csr_wr_data, exp_d);
        end
        if (exp_c && kind == 1) begin
            check({req, " sram idx"}, 128'(sram_wr_idx), 128'(idx));
            check({req, " sram data"}, 128'(sram_wr_data), exp_d[63:0]);
        end
        check({req, " R10 narrow strobe"}, 128'(nar_wr_en), 128'(kind == 3));
        if (kind == 3) check({req, " R10 narrow data"}, {nar_wr_addr, nar_wr_data}, {a[10:0], d});
        idle();
    endtask

    task automatic op_read(input logic [11:0] a, input string req);
        int kind, idx, dw, t;
        bit need;
        logic [31:0] exp;
        decode(a, kind, idx, dw);
        t = (kind == 1) ? 4096 + idx : idx;
        need = 0; exp = '0;
        if (kind <= 1) begin
            need = !m_lv || dw == 0 || m_lt != t;
            if (need) begin
                m_lv = 1; m_lt = t;
                m_ld = (kind == 0) ? csr_mem[idx] : {64'h0, sram_mem[idx]};
            end
            exp = m_ld[dw*32 +: 32];
        end else if (kind == 3) begin
            exp = nar_mem[a[10:0]];
        end
        host_addr = a; host_rd = 1;
        #1;
        check({req, " csr rd strobe"}, 128'(csr_rd_en), 128'(need && kind == 0));
        check({req, " sram rd strobe"}, 128'(sram_rd_en), 128'(need && kind == 1));
        check({req, " R10 narrow rd strobe"}, 128'(nar_rd_en), 128'(kind == 3));
        @(posedge clk); @(negedge clk);
        host_rd = 0;
        check({req, " R3 rvalid"}, 128'(host_rvalid), 128'(1));
        check({req, " rdata"}, 128'(host_rdata), 128'(exp));
        idle();
    endtask

    localparam int A = 5, B = 9, RX = 'h083, TX = 'h0A1, NR = 'h100;

    initial begin
        void'($urandom(32'd7341));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check("R1 csr_wr_en", 128'(csr_wr_en), 0);
        check("R1 sram_wr_en", 128'(sram_wr_en), 0);
        check("R1 nar_wr_en", 128'(nar_wr_en), 0);
        check("R1 rvalid", 128'(host_rvalid), 0);
        // R1 empty collector: lone descriptor top dword is all zero below
        op_write(csr_a(TX, 3), 32'hAAAA0001, "R1/R7 empty collector");

        // R5 wide write out of order
        op_write(csr_a(A, 2), 32'h22222222, "R5 dw2");
        op_write(csr_a(A, 0), 32'h00000000, "R5 dw0");
        op_write(csr_a(A, 3), 32'h33333333, "R5 dw3");
        op_write(csr_a(A, 1), 32'h11111111, "R5 dw1 completes");
        op_write(sram_a(3, 1), 32'h5A5A0001, "R5 sram dw1");
        op_write(sram_a(3, 0), 32'h5A5A0000, "R5 sram completes");

        // R6 interleaving two registers loses partial data
        op_write(csr_a(A, 0), 32'hA0A0A0A0, "R6 A0");
        op_write(csr_a(A, 1), 32'hA1A1A1A1, "R6 A1");
        for (int i = 0; i < 4; i++) op_write(csr_a(B, i), 32'hB0000000 + i, "R6 B full");
        op_write(csr_a(A, 2), 32'hA2A2A2A2, "R6 A2 no commit");
        op_write(csr_a(A, 3), 32'hA3A3A3A3, "R6 A3 no commit");
        op_write(csr_a(A, 0), 32'hC0C0C0C0, "R6 A0 again");
        op_write(csr_a(A, 1), 32'hC1C1C1C1, "R6 A restarted commit");

        // R7 descriptor partial then top dword keeps collected low dwords
        op_write(csr_a(RX, 1), 32'h0000D001, "R7 rx dw1");
        op_write(csr_a(RX, 3), 32'h0000D003, "R7 rx commit");
        // R8 discarded descriptor write leaves collector unchanged
        op_write(csr_a(A, 0), 32'hE0E0E0E0, "R8 A0");
        op_write(csr_a(A, 1), 32'hE1E1E1E1, "R8 A1");
        op_write(csr_a(RX, 0), 32'hDEAD0000, "R8 discarded");
        op_write(csr_a(RX, 3), 32'h0000F003, "R7 commit keeps other word");
        op_write(csr_a(A, 2), 32'hE2E2E2E2, "R8 A2");
        op_write(csr_a(A, 3), 32'hE3E3E3E3, "R8 A intact commit");
        // R10 narrow write in mid-collection
        op_write(csr_a(B, 0), 32'hF0F0F0F0, "R10 B0");
        op_write(csr_a(NR, 0), 32'h12345678, "R10 narrow write");
        op_write(csr_a(B, 1), 32'hF1F1F1F1, "R10 B1");
        op_write(csr_a(B, 2), 32'hF2F2F2F2, "R10 B2");
        op_write(csr_a(B, 3), 32'hF3F3F3F3, "R10 B commit");

        // R3/R4 read latch
        op_read(csr_a(A, 0), "R3 fresh A0");
        poke(0, A, 128'h99999999_88888888_77777777_66666666);
        op_read(csr_a(A, 2), "R4 stale A2");
        op_read(csr_a(A, 3), "R4 stale A3");
        op_read(csr_a(B, 2), "R3 other reg B2");
        op_read(csr_a(A, 3), "R3 switch back A3");
        op_read(csr_a(A, 0), "R3 dw0 resample");
        op_read(sram_a(3, 1), "R3 sram dw1");
        op_read(sram_a(3, 0), "R3 sram dw0");
        // R9 descriptor read
        op_read(csr_a(RX, 0), "R9 rx read");
        op_read(sram_a(3, 1), "R9 latch kept");
        op_read(csr_a(NR, 0), "R10 narrow read");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int pick, dw, sel;
            logic [11:0] a;
            pick = $urandom_range(0, 7);
            dw = $urandom_range(0, 3);
            case (pick)
                0: a = csr_a(A, dw);
                1: a = csr_a(B, dw);
                2: a = csr_a(RX, dw);
                3: a = csr_a(TX, dw);
                4: a = csr_a(NR + (dw & 1), dw);
                5: a = sram_a(3, dw & 1);
                default: a = sram_a(7, dw & 1);
            endcase
            sel = $urandom_range(0, 9);
            if (sel < 5) op_write(a, $urandom(), "R5/R6/R7/R8 random write");
            else if (sel < 9) op_read(a, "R3/R4/R9 random read");
            else poke(dw[0], (dw[0]) ? 7 : B, {$urandom(), $urandom(), $urandom(), $urandom()});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule